// File: doc/BRIEF.md
# Asynchronous Interrupt Pending Arbiter

This block sits in front of a core's exception entry logic and keeps track of three asynchronous causes: a level-driven external interrupt line, a one-shot decrementer underflow event, and a deferred floating-point enabled exception. It decides when one of them is offered to the entry logic and which one. The external line arrives as a strobe carrying the new level. The decrementer arrives as a single-cycle pulse. The enable and floating-point mode bits of the machine state and the floating-point summary exception bit are sampled every cycle.

Triggers do not deliver directly. A trigger arms one outstanding evaluation slot, and any number of triggers that arrive while the slot is armed merge into it. The slot is resolved at the first interruptible instruction boundary that comes after the cycle in which it was armed. On resolution the block issues a one-cycle delivery request. The request carries a vector offset, a mask of saved-state reason bits, and a one-hot source acknowledge. A decrementer delivery consumes its pending event. An external delivery does not, because the external level stays pending for as long as the line is held.

Top module: `irq_async_arb`

## Requirements
- R1: While reset is held and on the first cycle after it, req_valid, req_ofs, req_mask, req_src and proto_err are all zero, and nothing is pending or scheduled.
- R2: An ext_evt strobe with ext_lvl=1 makes the external source pending, and an ext_evt strobe with ext_lvl=0 clears it. Delivery never clears it, so a held level is delivered again after ee falls and rises.
- R3: A dec_evt pulse makes the decrementer source pending until it is delivered exactly once. While ee=0 the pulse is kept, not dropped.
- R4: The floating-point condition is (fe_mode != 0) and fp_sum=1, and it takes priority over every other source. It is delivered with req_ofs=0x700 and req_mask having bit 20 (enabled-exception reason) and bit 16 (subsequent-instruction reason) set, i.e. 32'h0011_0000. Every other delivery has req_mask=0.
- R5: Without the floating-point condition and with ee=1, a pending external source is delivered at 0x500 ahead of a pending decrementer at 0x900. With ee=0 neither is delivered.
- R6: An evaluation runs on a clock edge where a slot is armed and boundary=1. Its result appears on the outputs in the following cycle, so a trigger seen at edge k can be delivered at edge k+1 at the earliest. While boundary=0 the slot waits.
- R7: The slot is armed when a source becomes newly pending while ee=1, or when any of {ee, fe_mode, fp_sum} changes while a deliverable condition holds. Triggers that arrive while the slot is armed add nothing, so one slot gives at most one delivery.
- R8: If the enable bits stay steady, a source that stays pending is not delivered a second time. Only a new trigger from R7 brings another delivery.
- R9: proto_err pulses for one cycle, one cycle after an ext_evt strobe with ext_lvl=1 arrives while the external source is already pending and ee=1. It stays low in that case when ee=0.
- R10: req_src is one-hot with bit 0 = floating-point, bit 1 = external and bit 2 = decrementer. It is nonzero exactly when req_valid=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_evt | input | 1 | Strobe: external line changed or was re-asserted |
| ext_lvl | input | 1 | Level of the external line carried with ext_evt |
| dec_evt | input | 1 | One-cycle decrementer underflow event |
| ee | input | 1 | External interrupt enable bit of machine state |
| fe_mode | input | 2 | Floating-point exception mode bits |
| fp_sum | input | 1 | Floating-point summary exception bit |
| boundary | input | 1 | Core is at an interruptible instruction boundary |
| req_valid | output | 1 | One-cycle delivery request |
| req_ofs | output | VEC_W | Vector offset of the delivered cause |
| req_mask | output | SAVE_W | Saved-state bits to set on entry |
| req_src | output | 3 | One-hot acknowledge of the delivered source |
| proto_err | output | 1 | External re-assertion while pending and enabled |

## Verification
The stimulus targets a few specific failure modes. Both the external and decrementer sources are made pending before ee is raised, so a priority swap would show up as a 0x900 delivery first. The external level is held across an ee drop and rise to catch a design that clears it on delivery, which would deliver nothing the second time. The decrementer is raised while disabled to catch a design that drops the event. Several triggers are packed behind a low boundary to catch repeated deliveries from a single slot. The floating-point condition is raised while an external request is also eligible, so a wrong priority would deliver 0x500 without the reason mask.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FP   = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_DEC  = 2'd3
  } irq_src_e;

  localparam int SRC_N   = 3;
  localparam int IDX_FP  = 0;
  localparam int IDX_EXT = 1;
  localparam int IDX_DEC = 2;

  // floating-point deferred condition: any mode bit plus summary bit
  function automatic logic fp_armed(input logic [1:0] mode, input logic summ);
    return (|mode) & summ;
  endfunction

  // fixed priority: fp, then external (enabled), then decrementer (enabled)
  function automatic irq_src_e pick_src(input logic fpc, input logic en,
                                        input logic ext_p, input logic dec_p);
    if (fpc)               return SRC_FP;
    else if (en && ext_p)  return SRC_EXT;
    else if (en && dec_p)  return SRC_DEC;
    else                   return SRC_NONE;
  endfunction

  function automatic logic [SRC_N-1:0] src_onehot(input irq_src_e s);
    logic [SRC_N-1:0] v;
    v = '0;
    case (s)
      SRC_FP:  v[IDX_FP]  = 1'b1;
      SRC_EXT: v[IDX_EXT] = 1'b1;
      SRC_DEC: v[IDX_DEC] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/irq_src_track.sv
module irq_src_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_evt,
  input  logic ext_lvl,
  input  logic dec_evt,
  input  logic ee,
  input  logic dec_take,
  output logic ext_pend,
  output logic dec_pend,
  output logic ext_new,
  output logic proto_err
);

  logic ext_reassert;

  assign ext_new      = ext_evt & ext_lvl & ~ext_pend;
  assign ext_reassert = ext_evt & ext_lvl & ext_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_pend  <= 1'b0;
      dec_pend  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (ext_evt) ext_pend <= ext_lvl;
      // a fresh event in the delivery cycle survives the consume
      dec_pend  <= dec_evt | (dec_pend & ~dec_take);
      proto_err <= ext_reassert & ee;
    end
  end

endmodule

// File: rtl/irq_sched.sv
module irq_sched (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ee,
  input  logic [1:0] fe_mode,
  input  logic       fp_sum,
  input  logic       ext_new,
  input  logic       dec_evt,
  input  logic       ext_pend,
  input  logic       dec_pend,
  input  logic       boundary,
  output logic       fp_cond,
  output logic       trig,
  output logic       sched,
  output logic       eval
);
  import irq_arb_pkg::*;

  localparam int MSR_W = 4;

  logic [MSR_W-1:0] msr_now, msr_q;
  logic             msr_chg, cond_now, src_trig;

  assign msr_now  = {ee, fe_mode, fp_sum};
  assign msr_chg  = (msr_now != msr_q);
  assign fp_cond  = fp_armed(fe_mode, fp_sum);
  assign cond_now = fp_cond | (ee & (ext_pend | dec_pend));
  assign src_trig = (ext_new | dec_evt) & ee;
  assign trig     = src_trig | (msr_chg & cond_now);
  assign eval     = sched & boundary;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr_q <= '0;
      sched <= 1'b0;
    end else begin
      msr_q <= msr_now;
      sched <= trig | (sched & ~eval);
    end
  end

endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int               VEC_W      = 12,
  parameter int               SAVE_W     = 32,
  parameter int               FPE_BIT    = 20,
  parameter int               SUBSEQ_BIT = 16,
  parameter logic [VEC_W-1:0] VEC_FP     = 12'h700,
  parameter logic [VEC_W-1:0] VEC_EXT    = 12'h500,
  parameter logic [VEC_W-1:0] VEC_DEC    = 12'h900
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            eval,
  input  logic                            fp_cond,
  input  logic                            ee,
  input  logic                            ext_pend,
  input  logic                            dec_pend,
  output logic                            dec_take,
  output logic                            req_valid,
  output logic [VEC_W-1:0]                req_ofs,
  output logic [SAVE_W-1:0]               req_mask,
  output logic [irq_arb_pkg::SRC_N-1:0]   req_src
);
  import irq_arb_pkg::*;

  irq_src_e                 sel;
  logic [SRC_N-1:0]         sel_oh;
  logic [VEC_W-1:0]         ofs_n;
  logic [SAVE_W-1:0]        mask_n;
  logic [VEC_W-1:0]         vec_tab [SRC_N];

  assign vec_tab[IDX_FP]  = VEC_FP;
  assign vec_tab[IDX_EXT] = VEC_EXT;
  assign vec_tab[IDX_DEC] = VEC_DEC;

  assign sel      = eval ? pick_src(fp_cond, ee, ext_pend, dec_pend) : SRC_NONE;
  assign sel_oh   = src_onehot(sel);
  assign dec_take = sel_oh[IDX_DEC];

  // one-hot select of the offset, one term per source
  logic [VEC_W-1:0] ofs_term [SRC_N];
  for (genvar i = 0; i < SRC_N; i++) begin : g_ofs
    assign ofs_term[i] = sel_oh[i] ? vec_tab[i] : '0;
  end

  always_comb begin
    ofs_n = '0;
    for (int i = 0; i < SRC_N; i++) ofs_n = ofs_n | ofs_term[i];
    mask_n = '0;
    if (sel_oh[IDX_FP]) begin
      mask_n[FPE_BIT]    = 1'b1;
      mask_n[SUBSEQ_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_ofs   <= '0;
      req_mask  <= '0;
      req_src   <= '0;
    end else begin
      req_valid <= |sel_oh;
      req_ofs   <= ofs_n;
      req_mask  <= mask_n;
      req_src   <= sel_oh;
    end
  end

endmodule

// File: rtl/irq_async_arb.sv
module irq_async_arb #(
  parameter int               VEC_W      = 12,
  parameter int               SAVE_W     = 32,
  parameter int               FPE_BIT    = 20,
  parameter int               SUBSEQ_BIT = 16,
  parameter logic [VEC_W-1:0] VEC_FP     = 12'h700,
  parameter logic [VEC_W-1:0] VEC_EXT    = 12'h500,
  parameter logic [VEC_W-1:0] VEC_DEC    = 12'h900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_evt,
  input  logic              ext_lvl,
  input  logic              dec_evt,
  input  logic              ee,
  input  logic [1:0]        fe_mode,
  input  logic              fp_sum,
  input  logic              boundary,
  output logic              req_valid,
  output logic [VEC_W-1:0]  req_ofs,
  output logic [SAVE_W-1:0] req_mask,
  output logic [2:0]        req_src,
  output logic              proto_err
);

  logic ext_pend, dec_pend, ext_new, dec_take;
  logic fp_cond, trig, sched, eval;

  irq_src_track u_track (
    .clk, .rst_n, .ext_evt, .ext_lvl, .dec_evt, .ee, .dec_take,
    .ext_pend, .dec_pend, .ext_new, .proto_err
  );

  irq_sched u_sched (
    .clk, .rst_n, .ee, .fe_mode, .fp_sum, .ext_new, .dec_evt,
    .ext_pend, .dec_pend, .boundary, .fp_cond, .trig, .sched, .eval
  );

  irq_select #(
    .VEC_W(VEC_W), .SAVE_W(SAVE_W), .FPE_BIT(FPE_BIT), .SUBSEQ_BIT(SUBSEQ_BIT),
    .VEC_FP(VEC_FP), .VEC_EXT(VEC_EXT), .VEC_DEC(VEC_DEC)
  ) u_select (
    .clk, .rst_n, .eval, .fp_cond, .ee, .ext_pend, .dec_pend,
    .dec_take, .req_valid, .req_ofs, .req_mask, .req_src
  );

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int               VEC_W   = 12,
  parameter logic [VEC_W-1:0] VEC_FP  = 12'h700,
  parameter logic [VEC_W-1:0] VEC_EXT = 12'h500
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_evt,
  input logic             ext_lvl,
  input logic             dec_evt,
  input logic             ee,
  input logic             boundary,
  input logic             req_valid,
  input logic [VEC_W-1:0] req_ofs,
  input logic [2:0]       req_src,
  input logic             proto_err,
  input logic             dec_take,
  input logic             dec_pend,
  input logic             sched,
  input logic             eval
);

  // R10: acknowledge is one-hot and matches the request strobe
  p_src_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_src) && (req_valid == (req_src != 3'b000)));

  // R4: floating-point delivery uses its own offset
  p_fp_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src[0]) |-> (req_ofs == VEC_FP));

  // R5: external delivery needs the enable one cycle earlier
  p_ext_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src[1]) |-> (req_ofs == VEC_EXT && $past(ee)));

  // R3: a consumed decrementer event is gone unless a new one arrived
  p_dec_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_take && !dec_evt) |=> !dec_pend);

  // R6: a request follows a boundary cycle
  p_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(boundary));

  // R7: an armed slot stays armed until it is resolved
  p_slot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sched && !eval) |=> sched);

  // R9: error only after an enabled assertion strobe
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(ee && ext_evt && ext_lvl));

endmodule

bind irq_async_arb irq_arb_chk #(
  .VEC_W(VEC_W), .VEC_FP(VEC_FP), .VEC_EXT(VEC_EXT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt), .ext_lvl(ext_lvl),
  .dec_evt(dec_evt), .ee(ee), .boundary(boundary), .req_valid(req_valid),
  .req_ofs(req_ofs), .req_src(req_src), .proto_err(proto_err),
  .dec_take(dec_take), .dec_pend(dec_pend), .sched(sched), .eval(eval)
);

// File: tb/tb_irq_async_arb.sv
module tb_irq_async_arb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_evt, ext_lvl, dec_evt, ee, fp_sum, boundary;
  logic [1:0]  fe_mode;
  logic        req_valid, proto_err;
  logic [11:0] req_ofs;
  logic [31:0] req_mask;
  logic [2:0]  req_src;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int n_fp = 0, n_ext = 0, n_dec = 0, n_err = 0;

  // reference model state
  bit          m_ext, m_dec, m_sched;
  bit [3:0]    m_prev;
  bit          x_valid, x_err;
  bit [11:0]   x_ofs;
  bit [31:0]   x_mask;
  bit [2:0]    x_src;

  always #10 clk = ~clk;

  irq_async_arb dut (
    .clk, .rst_n, .ext_evt, .ext_lvl, .dec_evt, .ee, .fe_mode, .fp_sum,
    .boundary, .req_valid, .req_ofs, .req_mask, .req_src, .proto_err
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clock: model predicts from current inputs, then compare
  task automatic cyc();
    bit fpc, newx, cond, chg, trig, ev, take;
    fpc  = (fe_mode != 2'b00) && fp_sum;
    newx = ext_evt && ext_lvl && !m_ext;
    cond = fpc || (ee && (m_ext || m_dec));
    chg  = ({ee, fe_mode, fp_sum} != m_prev);
    trig = ((newx || dec_evt) && ee) || (chg && cond);
    ev   = m_sched && boundary;
    take = 0;
    x_valid = 0; x_ofs = 0; x_mask = 0; x_src = 0;
    if (ev) begin
      if (fpc) begin
        x_valid = 1; x_ofs = 12'h700; x_mask = 32'h0011_0000; x_src = 3'b001;
      end else if (ee && m_ext) begin
        x_valid = 1; x_ofs = 12'h500; x_src = 3'b010;
      end else if (ee && m_dec) begin
        x_valid = 1; x_ofs = 12'h900; x_src = 3'b100; take = 1;
      end
    end
    x_err = ext_evt && ext_lvl && m_ext && ee;
    if (ext_evt) m_ext = ext_lvl;
    m_dec   = dec_evt || (m_dec && !take);
    m_sched = trig || (m_sched && !ev);
    m_prev  = {ee, fe_mode, fp_sum};
    @(posedge clk);
    @(negedge clk);
    chk("R6", "req_valid", 32'(req_valid), 32'(x_valid));
    chk("R5", "req_ofs",   32'(req_ofs),   32'(x_ofs));
    chk("R4", "req_mask",  req_mask,       x_mask);
    chk("R10", "req_src",  32'(req_src),   32'(x_src));
    chk("R9", "proto_err", 32'(proto_err), 32'(x_err));
    if (req_src[0]) n_fp++;
    if (req_src[1]) n_ext++;
    if (req_src[2]) n_dec++;
    if (proto_err)  n_err++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic ext_strobe(input bit lvl);
    ext_evt = 1; ext_lvl = lvl; cyc(); ext_evt = 0; ext_lvl = 0;
  endtask

  task automatic dec_pulse();
    dec_evt = 1; cyc(); dec_evt = 0;
  endtask

  task automatic set_ee(input bit v);
    ee = v; cyc();
  endtask

  initial begin
    int b_fp, b_ext, b_dec;
    rst_n = 0; ext_evt = 0; ext_lvl = 0; dec_evt = 0; ee = 0;
    fe_mode = 0; fp_sum = 0; boundary = 1;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1", "valid in reset", 32'(req_valid), 0);
    chk("R1", "src in reset",   32'(req_src), 0);
    chk("R1", "err in reset",   32'(proto_err), 0);
    rst_n = 1;
    m_ext = 0; m_dec = 0; m_sched = 0; m_prev = 0;
    idle(2);
    chk("R1", "no delivery after reset", 32'(n_fp + n_ext + n_dec), 0);

    // R3: decrementer delivered once while enabled
    set_ee(1);
    dec_pulse(); idle(5);
    chk("R3", "dec delivered once", 32'(n_dec), 1);

    // R3: decrementer kept while disabled, delivered on enable (R7)
    set_ee(0);
    dec_pulse(); idle(4);
    chk("R3", "dec held while ee=0", 32'(n_dec), 1);
    set_ee(1); idle(4);
    chk("R7", "dec delivered on enable", 32'(n_dec), 2);

    // R2/R8: held external level, no repeat while enable steady
    ext_strobe(1); idle(4);
    chk("R2", "ext delivered", 32'(n_ext), 1);
    idle(6);
    chk("R8", "no redelivery", 32'(n_ext), 1);
    set_ee(0); set_ee(1); idle(4);
    chk("R2", "ext redelivered after re-enable", 32'(n_ext), 2);
    ext_strobe(0);
    set_ee(0); set_ee(1); idle(4);
    chk("R2", "cleared level not delivered", 32'(n_ext), 2);

    // R5: priority external over decrementer, and ee=0 blocks both
    set_ee(0);
    ext_strobe(1); dec_pulse(); idle(4);
    b_ext = n_ext; b_dec = n_dec;
    chk("R5", "nothing while disabled", 32'(n_ext + n_dec), 32'(2 + 2));
    set_ee(1); idle(4);
    chk("R5", "ext first", 32'(n_ext - b_ext), 1);
    chk("R5", "dec waits", 32'(n_dec - b_dec), 0);
    set_ee(0); ext_strobe(0); set_ee(1); idle(4);
    chk("R5", "dec after ext cleared", 32'(n_dec - b_dec), 1);

    // R4: floating-point beats an eligible external request
    set_ee(0); ext_strobe(1);
    b_fp = n_fp; b_ext = n_ext;
    ee = 1; fe_mode = 2'b01; fp_sum = 1; cyc(); idle(4);
    chk("R4", "fp delivered", 32'(n_fp - b_fp), 1);
    chk("R4", "ext not delivered with fp", 32'(n_ext - b_ext), 0);
    fp_sum = 0; fe_mode = 0; cyc(); idle(3);
    ext_strobe(0); idle(2);

    // R6: slot waits for a boundary
    boundary = 0; b_dec = n_dec;
    dec_pulse(); idle(5);
    chk("R6", "no delivery without boundary", 32'(n_dec - b_dec), 0);
    boundary = 1; idle(3);
    chk("R6", "delivery at boundary", 32'(n_dec - b_dec), 1);

    // R7: several triggers behind one slot give one delivery
    boundary = 0; b_dec = n_dec; b_ext = n_ext;
    dec_pulse(); ext_strobe(1); dec_pulse(); idle(2);
    boundary = 1; idle(5);
    chk("R7", "one delivery for merged triggers",
        32'((n_ext - b_ext) + (n_dec - b_dec)), 1);

    // R9: re-assert while pending
    b_ext = n_err;
    ext_strobe(1); idle(2);
    chk("R9", "error on enabled re-assert", 32'(n_err - b_ext), 1);
    set_ee(0); ext_strobe(1); idle(2);
    chk("R9", "no error while disabled", 32'(n_err - b_ext), 1);
    ext_strobe(0); idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule